// File: doc/BRIEF.md
# Partial-Field Word Transfer Unit

This block moves data between a sign-magnitude memory word and a register under control of a packed byte-range code. A word holds a sign and five 6-bit bytes. A load takes a contiguous run of bytes from a memory word, right-justifies it, and fills the unused upper bytes with zeros. It also works out the sign of the result. A store takes as many bytes as the field holds from the low end of a register and writes them into the selected positions of a memory word, and leaves every other byte as it was.

The caller presents one operation per strobe. The operation carries the memory word, the register value, the field code, the operation kind and the register class. One cycle later the unit returns the new register value (for loads) or the merged memory word (for stores), together with a done pulse. Field decode, address forming and the memory itself are handled outside this block.

Top module: `field_xfer`

## Requirements
- R1: A word is 31 bits: bit 30 is the sign (1 = minus), and byte p (1..5, numbered left to right) sits in bits [29-6(p-1) : 24-6(p-1)], so byte 1 is [29:24] and byte 5 is [5:0]. The field code has the left position L in bits [5:3] and the right position R in bits [2:0]. It selects positions L through R, where position 0 is the sign.
- R2: A load (op_kind 0) places bytes max(L,1)..R of mem_in at the least significant end of res_word and clears all higher bytes.
- R3: On a load, the result sign is the memory sign when L = 0 and plus when L > 0.
- R4: A negated load (op_kind 1) returns the same magnitude as a load with the opposite sign.
- R5: A store (op_kind 2) writes the rightmost R-max(L,1)+1 bytes of reg_in into positions max(L,1)..R of mem_in and returns the merged word. All other bytes are unchanged.
- R6: A store changes the memory sign only when L = 0, and in that case it writes the register sign.
- R7: A store-zero (op_kind 3) writes plus zero into the selected field, ignores reg_in, and leaves the rest of the word unchanged.
- R8: With reg_class 1 (index), bytes 1 to 3 of reg_in read as zero when it is stored.
- R9: A load or negated load with reg_class 1 or 2 whose result has a nonzero byte in positions 1 to 3 raises idx_err together with done.
- R10: With reg_class 2 (jump), a store reads bytes 1 to 3 as zero and the sign as plus. The usual field for this is (0:2), code 2. reg_class 3 acts as class 0 (full word).
- R11: A field code with L > R or R > 5 raises illegal_field together with done, keeps idx_err low, and leaves res_word unchanged.
- R12: done is high for exactly one cycle in the cycle after each op_valid strobe. res_word and the flags are registered and are valid in that same cycle. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 0 load, 1 negated load, 2 store, 3 store zero |
| reg_class | input | 2 | 0 full word, 1 index, 2 jump, 3 full word |
| field | input | 6 | Field code {L, R} |
| mem_in | input | 31 | Memory word operand |
| reg_in | input | 31 | Register operand |
| done | output | 1 | One-cycle completion pulse |
| res_word | output | 31 | Loaded register value or merged memory word |
| illegal_field | output | 1 | Field code out of range |
| idx_err | output | 1 | Index-class load overflowed bytes 1 to 3 |

## Verification
Every result passes through a single register stage. A wrong mask, shift or sign choice therefore shows on res_word in the cycle right after the strobe, as a misplaced byte, a stray byte outside the field or a wrong sign bit. A stuck or missing done pulse, or a flag that is raised when it should not be, is also seen at that same edge. Illegal codes are checked against the result of the previous legal operation, so a write that gets through on an illegal code shows at once.

// File: rtl/field_xfer.sv
module field_xfer #(
  parameter int BYTE_W    = 6,
  parameter int NBYTES    = 5,
  parameter int IDX_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op_kind,
  input  logic [1:0]  reg_class,
  input  logic [5:0]  field,
  input  logic [30:0] mem_in,
  input  logic [30:0] reg_in,
  output logic        done,
  output logic [30:0] res_word,
  output logic        illegal_field,
  output logic        idx_err
);
  localparam int MAG_W  = BYTE_W * NBYTES;
  localparam int WORD_W = MAG_W + 1;
  localparam int IDX_W  = BYTE_W * IDX_BYTES;

  localparam logic [1:0] K_LOAD = 2'd0, K_LOADN = 2'd1, K_STORE = 2'd2, K_ZERO = 2'd3;
  localparam logic [1:0] C_FULL = 2'd0, C_INDEX = 2'd1, C_JUMP = 2'd2;

  logic [2:0]       fl, fr;
  logic             legal, is_store, narrow;
  logic [MAG_W-1:0] fmask, mem_mag, src_mag, ld_mag, st_mag;
  logic [7:0]       sh_bits;
  logic             mem_sign, src_sign, ld_sign, st_sign;
  logic [WORD_W-1:0] next_word;
  logic             idx_bad;

  assign fl       = field[5:3];
  assign fr       = field[2:0];
  assign legal    = (fl <= fr) && (fr <= 3'(NBYTES));
  assign is_store = op_kind[1];
  assign narrow   = (reg_class == C_INDEX) || (reg_class == C_JUMP);
  assign mem_sign = mem_in[WORD_W-1];
  assign mem_mag  = mem_in[MAG_W-1:0];
  assign sh_bits  = 8'(BYTE_W) * {5'd0, 3'(NBYTES) - fr};

  for (genvar p = 1; p <= NBYTES; p++) begin : g_mask
    assign fmask[MAG_W-BYTE_W*p +: BYTE_W] =
      {BYTE_W{(3'(p) >= fl) && (3'(p) <= fr)}};
  end

  always_comb begin
    src_mag  = reg_in[MAG_W-1:0];
    src_sign = reg_in[WORD_W-1];
    if (narrow) src_mag = {{(MAG_W-IDX_W){1'b0}}, reg_in[IDX_W-1:0]};
    if (reg_class == C_JUMP) src_sign = 1'b0;
    if (op_kind == K_ZERO) begin
      src_mag  = '0;
      src_sign = 1'b0;
    end
  end

  assign ld_mag  = (mem_mag & fmask) >> sh_bits;
  assign ld_sign = ((fl == 3'd0) ? mem_sign : 1'b0) ^ (op_kind == K_LOADN);
  assign st_mag  = (mem_mag & ~fmask) | ((src_mag << sh_bits) & fmask);
  assign st_sign = (fl == 3'd0) ? src_sign : mem_sign;
  assign next_word = is_store ? {st_sign, st_mag} : {ld_sign, ld_mag};
  assign idx_bad = !is_store && narrow && (|(ld_mag >> IDX_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done          <= 1'b0;
      res_word      <= '0;
      illegal_field <= 1'b0;
      idx_err       <= 1'b0;
    end else begin
      done          <= op_valid;
      illegal_field <= op_valid && !legal;
      idx_err       <= op_valid && legal && idx_bad;
      if (op_valid && legal) res_word <= next_word;
    end
  end

  assert_done_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !done);
  assert_illegal_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !legal) |=> (illegal_field && !idx_err && $stable(res_word)));
  assert_load_plus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && legal && op_kind == K_LOAD && fl != 3'd0) |=> !res_word[WORD_W-1]);
  assert_store_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && legal && is_store) |=>
      (((res_word[MAG_W-1:0] ^ $past(mem_mag)) & $past(~fmask)) == '0));
  assert_store_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && legal && is_store && fl != 3'd0) |=> (res_word[WORD_W-1] == $past(mem_sign)));
  assert_jump_plus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && legal && is_store && reg_class == C_JUMP && fl == 3'd0) |=> !res_word[WORD_W-1]);
  assert_zero_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && legal && op_kind == K_ZERO) |=> ((res_word[MAG_W-1:0] & $past(fmask)) == '0));
endmodule

// File: tb/field_xfer_bench.sv
module field_xfer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [1:0]  reg_class = '0;
  logic [5:0]  field = '0;
  logic [30:0] mem_in = '0;
  logic [30:0] reg_in = '0;
  logic        done, illegal_field, idx_err;
  logic [30:0] res_word;

  int total = 0;
  int bad = 0;
  logic [30:0] prev_res = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  field_xfer u_field_xfer (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .reg_class(reg_class), .field(field), .mem_in(mem_in), .reg_in(reg_in),
    .done(done), .res_word(res_word), .illegal_field(illegal_field), .idx_err(idx_err)
  );

  function automatic logic [5:0] byte_of(logic [30:0] w, int p);
    return w[30-6*p +: 6];
  endfunction

  function automatic void model(input logic [1:0] k, input logic [1:0] c,
                                input logic [5:0] f, input logic [30:0] m,
                                input logic [30:0] r, input logic [30:0] prev,
                                output logic [30:0] res, output bit ill, output bit ie);
    int l, rr, ls, n;
    logic [5:0] ob [1:5];
    logic [5:0] sb [1:5];
    logic sgn;
    bit nar;
    l = int'(f[5:3]); rr = int'(f[2:0]);
    ill = 0; ie = 0; res = prev;
    if (l > rr || rr > 5) begin ill = 1; return; end
    ls = (l < 1) ? 1 : l;
    n  = (rr >= ls) ? rr - ls + 1 : 0;
    nar = (c == 2'd1) || (c == 2'd2);
    if (k < 2) begin
      for (int p = 1; p <= 5; p++) ob[p] = 6'd0;
      for (int q = 0; q < n; q++) ob[5-q] = byte_of(m, rr-q);
      sgn = (l == 0) ? m[30] : 1'b0;
      if (k == 2'd1) sgn = ~sgn;
      if (nar && (ob[1] != 0 || ob[2] != 0 || ob[3] != 0)) ie = 1;
    end else begin
      for (int p = 1; p <= 5; p++) begin
        ob[p] = byte_of(m, p);
        sb[p] = (k == 2'd3 || (nar && p <= 3)) ? 6'd0 : byte_of(r, p);
      end
      for (int q = 0; q < n; q++) ob[rr-q] = sb[5-q];
      sgn = m[30];
      if (l == 0) sgn = (k == 2'd3 || c == 2'd2) ? 1'b0 : r[30];
    end
    res = {sgn, ob[1], ob[2], ob[3], ob[4], ob[5]};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(logic [1:0] k, logic [1:0] c, logic [5:0] f,
                        logic [30:0] m, logic [30:0] r, string tag);
    logic [30:0] er; bit ei, ee;
    model(k, c, f, m, r, prev_res, er, ei, ee);
    @(negedge clk);
    op_valid = 1; op_kind = k; reg_class = c; field = f; mem_in = m; reg_in = r;
    @(negedge clk);
    op_valid = 0;
    check(done == 1'b1, "R12", "done", 32'(done), 32'd1);
    check(res_word == er, tag, "res_word", 32'(res_word), 32'(er));
    check(illegal_field == ei && idx_err == ee, ei ? "R11" : "R9", "flags",
          {30'd0, illegal_field, idx_err}, {30'd0, ei, ee});
    prev_res = er;
  endtask

  function automatic string tag_of(logic [1:0] k, logic [1:0] c);
    if (k == 2'd0) return "R2";
    if (k == 2'd1) return "R4";
    if (k == 2'd3) return "R7";
    if (c == 2'd1) return "R8";
    if (c == 2'd2) return "R10";
    return "R5";
  endfunction

  localparam logic [30:0] MW = {1'b1, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5};
  localparam logic [30:0] RW = {1'b0, 6'd10, 6'd11, 6'd12, 6'd13, 6'd14};

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(done == 0 && res_word == 0 && illegal_field == 0 && idx_err == 0,
          "R12", "reset", {res_word, done}, 32'd0);
    rst_n = 1;
    run_op(2'd0, 2'd0, 6'o05, MW, RW, "R1");
    run_op(2'd0, 2'd0, 6'o15, MW, RW, "R3");
    run_op(2'd0, 2'd0, 6'o44, MW, RW, "R2");
    run_op(2'd0, 2'd0, 6'o00, MW, RW, "R3");
    run_op(2'd1, 2'd0, 6'o05, MW, RW, "R4");
    run_op(2'd1, 2'd0, 6'o13, MW, RW, "R4");
    run_op(2'd2, 2'd0, 6'o11, MW, RW, "R5");
    run_op(2'd2, 2'd0, 6'o02, MW, RW, "R6");
    run_op(2'd2, 2'd0, 6'o24, {1'b0, 30'h0ABCDEF}, {1'b1, 30'h3FFFFFFF}, "R6");
    run_op(2'd3, 2'd0, 6'o24, MW, RW, "R7");
    run_op(2'd3, 2'd0, 6'o05, MW, RW, "R7");
    run_op(2'd2, 2'd1, 6'o15, MW, {1'b1, 30'h3FFFFFFF}, "R8");
    run_op(2'd2, 2'd2, 6'o02, MW, {1'b1, 30'h3FFFFFFF}, "R10");
    run_op(2'd0, 2'd1, 6'o05, MW, RW, "R9");
    run_op(2'd0, 2'd1, 6'o45, MW, RW, "R9");
    run_op(2'd0, 2'd0, 6'o32, MW, RW, "R11");
    run_op(2'd2, 2'd0, 6'o06, MW, RW, "R11");
    @(negedge clk);
    check(done == 0 && illegal_field == 0, "R12", "idle done", 32'(done), 32'd0);
    for (int i = 0; i < 400; i++) begin
      logic [5:0] f; logic [1:0] k, c;
      k = 2'($urandom_range(0, 3));
      c = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) begin
        int r0 = $urandom_range(0, 5);
        int l0 = $urandom_range(0, r0);
        f = {3'(l0), 3'(r0)};
      end else f = 6'($urandom_range(0, 63));
      run_op(k, c, f, 31'($urandom), 31'($urandom), tag_of(k, c));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule